// File: doc/BRIEF.md
# Halt-Mode Clock and Power Sequencer

This block sequences a device into its deepest low-power halt state and back out again. When the processor raises a halt request, the sequencer lets the clocks keep running for a flush interval. The length of that interval depends on a 2-bit divide setting. After the flush it gates the core and peripheral clocks, powers down the PLL and switches off the crystal oscillator. Two keep-alive bits can hold the internal oscillator and the watchdog clock alive through halt.

A falling edge on the wake pin brings the device back. The edge is ignored during a short lockout window right after halt entry. Once the edge is accepted, the sequencer powers the oscillator up and waits for it to settle. It then powers the PLL and waits a fixed lock interval. Finally it re-opens the core clock and, if enabled, raises a one-cycle wake interrupt.

The analog oscillator and PLL are modelled by cycle counters that run on the free-running reference clock. All intervals are parameters, and the defaults are small so that simulation stays short.

Top module: `hms_top`

## Requirements
- R1: After a halt request is accepted, the sequencer stays in the flush state for exactly FLUSH_BASE cycles when divSel is 0 or 1, 2*FLUSH_BASE when it is 2, and 4*FLUSH_BASE when it is 3. divSel is sampled in the cycle the request is taken.
- R2: In the run and flush states, coreClkEn, periphClkEn, pllPwrEn and xtalPwrEn are all 1. In the halted state, coreClkEn, periphClkEn and pllPwrEn are 0.
- R3: xtalPwrEn is 0 only in the halted state. In that state intOscEn equals keepIntOsc and wdogClkEn equals keepWdog; in every other state both are 1.
- R4: A wake fall that reaches the sequencer during the first LOCKOUT_CYC halted cycles is dropped rather than queued, and the state stays halted.
- R5: wakePin passes through a two-stage synchroniser and an edge flop. A fall of the pin before clock edge k is acted on at edge k+2. An accepted fall moves the state from halted to oscillator start.
- R6: The oscillator-start state lasts OSC_SETTLE_CYC cycles with xtalPwrEn=1 and pllPwrEn=0. It is followed by the PLL-lock state, which lasts PLL_LOCK_CYC cycles with pllPwrEn=1. coreClkEn stays 0 in both states.
- R7: On leaving PLL lock, the state returns to run with coreClkEn=1. wakeIrq is high for exactly the first run cycle when wakeIntEn is 1, and stays 0 otherwise.
- R8: haltReq has an effect only in the run state. Asserting it in any other state leaves the state unchanged.
- R9: The status output encodes run=0, flush=1, halted=2, oscillator start=3, PLL lock=4, and no other value appears.
- R10: A wake fall that arrives during the flush state is dropped, and the sequence still enters the halted state.
- R11: After reset the status is run, all clock and power enables are 1, and wakeIrq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference (oscillator) clock |
| rstN | input | 1 | Active-low asynchronous reset |
| haltReq | input | 1 | Halt request from the processor |
| divSel | input | 2 | Divide setting that selects the flush length |
| keepIntOsc | input | 1 | Keep the internal oscillator running in halt |
| keepWdog | input | 1 | Keep the watchdog clock running in halt |
| wakeIntEn | input | 1 | Enable the wake interrupt pulse |
| wakePin | input | 1 | Asynchronous wake pin, active on its falling edge |
| coreClkEn | output | 1 | Core clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| pllPwrEn | output | 1 | PLL power enable |
| xtalPwrEn | output | 1 | Crystal oscillator power enable |
| intOscEn | output | 1 | Internal oscillator enable |
| wdogClkEn | output | 1 | Watchdog clock enable |
| wakeIrq | output | 1 | One-cycle wake interrupt request |
| status | output | 3 | Sequencer state code |

## Verification
The assertions check the state graph on every cycle:
- run can move only to flush;
- halted can be entered only from flush;
- the lockout holds for its full window, using a counter in the checker;
- the PLL powers up only after an oscillator-start phase;
- the wake interrupt appears only on the return from PLL lock;
- the status code stays in range.

The exact interval lengths need the bench's scenarios: the flush length for each divide setting, and the settle and lock durations. So do the boundary of the wake lockout, seen through the synchroniser delay, the keep-alive bit effects, and the dropping of wake edges during flush.

// File: rtl/hms_pkg.sv
package hms_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_FLUSH  = 3'd1,
    ST_HALTED = 3'd2,
    ST_OSC    = 3'd3,
    ST_PLL    = 3'd4
  } hmsState_e;

  // load strobes from control to the interval counter
  typedef struct packed {
    logic ldFlush;
    logic ldLockout;
    logic ldOsc;
    logic ldPll;
  } hmsStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hms_datapath.sv
module hms_datapath
  import hms_pkg::*;
#(
  parameter int FLUSH_BASE     = 16,
  parameter int OSC_SETTLE_CYC = 12,
  parameter int PLL_LOCK_CYC   = 40,
  parameter int LOCKOUT_CYC    = 5,
  parameter int CW             = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  hmsStrobe_t strobe,
  input  logic [1:0] divSel,
  input  logic       wakePin,
  output logic       cntZero,
  output logic       wakeFall
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] flushLoad;
  logic [2:0]    wakeSh;

  // flush length scales with the divide setting: x1, x1, x2, x4
  always_comb begin
    unique case (divSel)
      2'd2:    flushLoad = CW'(FLUSH_BASE * 2 - 1);
      2'd3:    flushLoad = CW'(FLUSH_BASE * 4 - 1);
      default: flushLoad = CW'(FLUSH_BASE - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.ldFlush) begin
      cnt <= flushLoad;
    end else if (strobe.ldLockout) begin
      cnt <= CW'(LOCKOUT_CYC);
    end else if (strobe.ldOsc) begin
      cnt <= CW'(OSC_SETTLE_CYC - 1);
    end else if (strobe.ldPll) begin
      cnt <= CW'(PLL_LOCK_CYC - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  // two synchroniser stages followed by the edge-detect flop; pin idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeSh <= 3'b111;
    else       wakeSh <= {wakeSh[1:0], wakePin};
  end

  assign wakeFall = wakeSh[2] & ~wakeSh[1];

endmodule

// File: rtl/hms_ctrl.sv
module hms_ctrl
  import hms_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltReq,
  input  logic       wakeIntEn,
  input  logic       keepIntOsc,
  input  logic       keepWdog,
  input  logic       cntZero,
  input  logic       wakeFall,
  output hmsStrobe_t strobe,
  output hmsState_e  state,
  output logic       coreClkEn,
  output logic       periphClkEn,
  output logic       pllPwrEn,
  output logic       xtalPwrEn,
  output logic       intOscEn,
  output logic       wdogClkEn,
  output logic       wakeIrq
);

  hmsState_e stateNxt;
  logic      irqNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    irqNxt   = 1'b0;
    unique case (state)
      ST_RUN: if (haltReq) begin
        stateNxt       = ST_FLUSH;
        strobe.ldFlush = 1'b1;
      end
      ST_FLUSH: if (cntZero) begin
        stateNxt         = ST_HALTED;
        strobe.ldLockout = 1'b1;
      end
      ST_HALTED: if (cntZero && wakeFall) begin
        stateNxt     = ST_OSC;
        strobe.ldOsc = 1'b1;
      end
      ST_OSC: if (cntZero) begin
        stateNxt     = ST_PLL;
        strobe.ldPll = 1'b1;
      end
      ST_PLL: if (cntZero) begin
        stateNxt = ST_RUN;
        irqNxt   = wakeIntEn;
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      wakeIrq <= 1'b0;
    end else begin
      state   <= stateNxt;
      wakeIrq <= irqNxt;
    end
  end

  logic clocksOn, inHalt;
  assign clocksOn    = (state == ST_RUN) || (state == ST_FLUSH);
  assign inHalt      = (state == ST_HALTED);
  assign coreClkEn   = clocksOn;
  assign periphClkEn = clocksOn;
  assign xtalPwrEn   = !inHalt;
  assign pllPwrEn    = !inHalt && (state != ST_OSC);
  assign intOscEn    = !inHalt || keepIntOsc;
  assign wdogClkEn   = !inHalt || keepWdog;

endmodule

// File: rtl/hms_top.sv
module hms_top
  import hms_pkg::*;
#(
  parameter int FLUSH_BASE     = 16,
  parameter int OSC_SETTLE_CYC = 12,
  parameter int PLL_LOCK_CYC   = 40,
  parameter int LOCKOUT_CYC    = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltReq,
  input  logic [1:0] divSel,
  input  logic       keepIntOsc,
  input  logic       keepWdog,
  input  logic       wakeIntEn,
  input  logic       wakePin,
  output logic       coreClkEn,
  output logic       periphClkEn,
  output logic       pllPwrEn,
  output logic       xtalPwrEn,
  output logic       intOscEn,
  output logic       wdogClkEn,
  output logic       wakeIrq,
  output logic [2:0] status
);

  localparam int MAX_CNT = maxOf(maxOf(FLUSH_BASE * 4, OSC_SETTLE_CYC),
                                 maxOf(PLL_LOCK_CYC, LOCKOUT_CYC));
  localparam int CW = $clog2(MAX_CNT + 1);

  hmsStrobe_t strobe;
  hmsState_e  state;
  logic       cntZero;
  logic       wakeFall;

  hms_datapath #(
    .FLUSH_BASE(FLUSH_BASE), .OSC_SETTLE_CYC(OSC_SETTLE_CYC),
    .PLL_LOCK_CYC(PLL_LOCK_CYC), .LOCKOUT_CYC(LOCKOUT_CYC), .CW(CW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divSel(divSel),
    .wakePin(wakePin), .cntZero(cntZero), .wakeFall(wakeFall)
  );

  hms_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .wakeIntEn(wakeIntEn),
    .keepIntOsc(keepIntOsc), .keepWdog(keepWdog), .cntZero(cntZero),
    .wakeFall(wakeFall), .strobe(strobe), .state(state),
    .coreClkEn(coreClkEn), .periphClkEn(periphClkEn), .pllPwrEn(pllPwrEn),
    .xtalPwrEn(xtalPwrEn), .intOscEn(intOscEn), .wdogClkEn(wdogClkEn),
    .wakeIrq(wakeIrq)
  );

  assign status = state;

endmodule

// File: rtl/hms_checker.sv
module hms_checker #(
  parameter int LOCKOUT_CYC = 5
) (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] status,
  input logic       pllPwrEn,
  input logic       xtalPwrEn,
  input logic       wakeIrq
);

  logic [7:0] haltCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 haltCnt <= '0;
    else if (status != 3'd2)   haltCnt <= '0;
    else if (haltCnt != 8'hFF) haltCnt <= haltCnt + 1'b1;
  end

  p_code_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    status <= 3'd4);

  p_run_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    status == 3'd0 |=> status == 3'd0 || status == 3'd1);

  p_halt_entry_r1: assert property (@(posedge clk) disable iff (!rstN)
    status == 3'd2 && $past(status) != 3'd2 |-> $past(status) == 3'd1);

  p_lockout_r4: assert property (@(posedge clk) disable iff (!rstN)
    status == 3'd2 && haltCnt < 8'(LOCKOUT_CYC) |=> status == 3'd2);

  p_pll_after_osc_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllPwrEn) |-> xtalPwrEn && $past(status) == 3'd3);

  p_irq_on_return_r7: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> status == 3'd0 && $past(status) == 3'd4);

endmodule

bind hms_top hms_checker #(.LOCKOUT_CYC(LOCKOUT_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .status(status), .pllPwrEn(pllPwrEn),
  .xtalPwrEn(xtalPwrEn), .wakeIrq(wakeIrq)
);

// File: tb/sim_hms_top.sv
module sim_hms_top;

  localparam int FLUSH_BASE = 16;
  localparam int OSC_CYC    = 12;
  localparam int PLL_CYC    = 40;
  localparam int LOCKOUT    = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltReq = 1'b0;
  logic [1:0] divSel = 2'd0;
  logic keepIntOsc = 1'b0, keepWdog = 1'b0, wakeIntEn = 1'b0;
  logic wakePin = 1'b1;
  logic coreClkEn, periphClkEn, pllPwrEn, xtalPwrEn, intOscEn, wdogClkEn, wakeIrq;
  logic [2:0] status;

  int nTests = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  hms_top #(
    .FLUSH_BASE(FLUSH_BASE), .OSC_SETTLE_CYC(OSC_CYC),
    .PLL_LOCK_CYC(PLL_CYC), .LOCKOUT_CYC(LOCKOUT)
  ) u0 (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .divSel(divSel),
    .keepIntOsc(keepIntOsc), .keepWdog(keepWdog), .wakeIntEn(wakeIntEn),
    .wakePin(wakePin), .coreClkEn(coreClkEn), .periphClkEn(periphClkEn),
    .pllPwrEn(pllPwrEn), .xtalPwrEn(xtalPwrEn), .intOscEn(intOscEn),
    .wdogClkEn(wdogClkEn), .wakeIrq(wakeIrq), .status(status)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int flushLen(input int div);
    return (div == 3) ? FLUSH_BASE * 4 : (div == 2) ? FLUSH_BASE * 2 : FLUSH_BASE;
  endfunction

  task automatic runCycle(input int div, input bit kI, input bit kW,
                          input bit irqEn, input int d);
    int n;
    int j;
    bit accept;
    @(negedge clk);
    divSel = 2'(div); keepIntOsc = kI; keepWdog = kW; wakeIntEn = irqEn;
    haltReq = 1'b1;
    @(negedge clk);
    haltReq = 1'b0;
    chkEq("R9 flush code", status, 1);
    // R10: wake pin falls and recovers inside the flush window
    wakePin = 1'b0;
    n = 0;
    repeat (4) begin
      chkEq("R2 clocks on in flush", {coreClkEn, periphClkEn, pllPwrEn, xtalPwrEn}, 15);
      n++;
      @(negedge clk);
    end
    wakePin = 1'b1;
    while (status == 3'd1 && n < 300) begin n++; @(negedge clk); end
    chkEq("R1 flush length", n, flushLen(div));
    chkEq("R10 flush wake dropped", status, 2);
    chkEq("R2 gated in halt", {coreClkEn, periphClkEn, pllPwrEn}, 0);
    chkEq("R3 xtal off in halt", xtalPwrEn, 0);
    chkEq("R3 intosc keep", intOscEn, kI);
    chkEq("R3 wdog keep", wdogClkEn, kW);
    // R8: halt request while halted is ignored
    haltReq = 1'b1;
    @(negedge clk);
    haltReq = 1'b0;
    chkEq("R8 halt req ignored", status, 2);
    j = 1;
    while (j < d) begin @(negedge clk); j++; end
    wakePin = 1'b0;
    accept = (d + 2 >= LOCKOUT);
    n = 0;
    while (status == 3'd2 && n < 20) begin @(negedge clk); n++; end
    if (accept) begin
      chkEq("R5 wake latency", n, 3);
    end else begin
      chkEq("R4 early wake dropped", n, 20);
      wakePin = 1'b1;
      repeat (3) @(negedge clk);
      wakePin = 1'b0;
      n = 0;
      while (status == 3'd2 && n < 20) begin @(negedge clk); n++; end
      chkEq("R5 wake latency after lockout", n, 3);
    end
    chkEq("R9 osc code", status, 3);
    chkEq("R6 osc phase enables", {xtalPwrEn, pllPwrEn, coreClkEn}, 4);
    n = 0;
    while (status == 3'd3 && n < 300) begin n++; @(negedge clk); end
    chkEq("R6 osc settle length", n, OSC_CYC);
    chkEq("R9 pll code", status, 4);
    chkEq("R6 pll phase enables", {xtalPwrEn, pllPwrEn, coreClkEn}, 6);
    n = 0;
    while (status == 3'd4 && n < 300) begin n++; @(negedge clk); end
    chkEq("R6 pll lock length", n, PLL_CYC);
    chkEq("R7 back to run", status, 0);
    chkEq("R7 core clock on", coreClkEn, 1);
    chkEq("R7 wake irq", wakeIrq, irqEn);
    @(negedge clk);
    chkEq("R7 irq one cycle", wakeIrq, 0);
    wakePin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chkEq("R11 reset status", status, 0);
    chkEq("R11 reset enables",
          {coreClkEn, periphClkEn, pllPwrEn, xtalPwrEn, intOscEn, wdogClkEn}, 63);
    chkEq("R11 reset irq", wakeIrq, 0);
    for (int div = 0; div < 4; div++) begin
      for (int k = 0; k < 4; k++) begin
        runCycle(div, k[0], k[1], (div + k) % 2 == 0, 1 + ((div * 4 + k) % 6));
      end
    end
    finishRun();
  end

endmodule